// File: doc/BRIEF.md
# Multiplexed Parallel Port Pin Controller

This block controls a 16-pin parallel port. Each pin is either a general-purpose I/O or a dedicated peripheral signal. Four registers choose what each pin does: an output latch, a direction mask, a function-select mask and an open-drain mask. Software writes and reads them over a simple single-cycle register bus.

Within a pin, the function-select bit and the direction bit together pick the driver source and the route of the incoming value. With select clear, the pin is a plain GPIO and the direction bit gates the latch onto the pad. With select set, direction 0 makes the pin a dedicated input and direction 1 a dedicated output. Three pins have fixed special roles:

- Pin 3 is a clock input or a baud-rate clock output. As a GPIO it still feeds the baud-rate clock to its peripheral input.
- Pin 9 is a clear-to-send input or a second transmit-data output. As a GPIO its peripheral input comes from a pin on another port.
- Pin 12 has only a transmit-data output role and may be open-drain.

The controller has no sequencing state. Its only registers are the four configuration registers and the two-stage input synchronizer.

Top module: `pport_ctrl`

## Requirements
- R1: After synchronous reset, all four registers read 0, every `pin_oe` bit is 0, and `pin_out` is 0.
- R2: A write with `wr_en` high stores `wdata` at the next rising edge into the register chosen by `addr`: 0 is the output latch, 1 the direction mask, 2 the function-select mask and 3 the open-drain mask. Reading `addr` 1, 2 or 3 returns that register combinationally.
- R3: A GPIO pin (select 0, direction 1) without open-drain asserts `pin_oe` and drives `pin_out` with its latch bit.
- R4: A GPIO pin with direction 0 keeps `pin_oe` low, and `pin_out` still carries its latch bit.
- R5: Reading `addr` 0 returns the pad values `pin_in` after a two-flop synchronizer, for every pin and in every mode. This holds for pins in dedicated mode too, never the latch.
- R6: On an open-drain capable pin (mask 16'hF0F0, bits 4-7 and 12-15) with its open-drain bit set, a drive value of 0 gives `pin_oe`=1 and `pin_out`=0. A drive value of 1 gives `pin_oe`=0 and `pin_out`=0.
- R7: On pins outside the open-drain capable mask, the open-drain bit is ignored and the pin behaves as push-pull.
- R8: A dedicated input pin (select 1, direction 0) keeps `pin_oe` low whatever its latch holds, and passes the raw `pin_in` bit to `dev_in`. On a plain pin that is not a dedicated input, `dev_in` is 0.
- R9: A dedicated output pin (select 1, direction 1) asserts `pin_oe` and drives `dev_out` of that bit, subject to open-drain as in R6.
- R10: Pin 3 drives `brg_clk` when it is a dedicated output. When it is not a dedicated input, `dev_in[3]` follows `brg_clk`.
- R11: Pin 9, when its select bit is 0, feeds `dev_in[9]` from `alt_cts_in`.
- R12: Pin 12 with select 1 and direction 0 has no function: `pin_oe[12]` is 0 and `dev_in[12]` is 0 even with its pad high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational on `addr` |
| pin_in | input | 16 | Pad input values |
| pin_oe | output | 16 | Pad output enables |
| pin_out | output | 16 | Pad output values |
| dev_out | input | 16 | Per-pin peripheral output values |
| dev_in | output | 16 | Per-pin peripheral input values |
| brg_clk | input | 1 | Baud-rate clock for pin 3 |
| alt_cts_in | input | 1 | Fallback clear-to-send from another port |

## Verification
The port is driven through each mode combination:

- An all-GPIO output pattern and an all-GPIO input pattern separate the direction bit's effect from that of the select bit.
- All-dedicated input and output patterns show that the select bit reroutes both the driver and `dev_in`.
- Complementary latch patterns of 16'h00FF and 16'hFF00 with every open-drain bit set separate the capable pins from the ignoring ones, both driving low and releasing.
- Toggling `brg_clk` and `alt_cts_in` while the special pins are GPIO or in their unused dedicated mode shows that each fallback source reaches only its own pin.

// File: rtl/pport_pkg.sv
package pport_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_SEL  = 2'd2,
        REG_OD   = 2'd3
    } pp_reg_e;

    typedef enum logic [1:0] {
        PIN_PLAIN,
        PIN_CLK,
        PIN_CTS,
        PIN_TXD0
    } pin_kind_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad,
    output logic [WIDTH-1:0] pad_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            warm_q   <= '0;
        end else begin
            stage1_q <= pad;
            stage2_q <= stage1_q;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    assign pad_sync = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (pad_sync == $past(pad, 2))); // R5
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pad_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] sel_q,
    output logic [WIDTH-1:0] od_q
);
    pp_reg_e reg_sel;
    assign reg_sel = pp_reg_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '0;
            sel_q <= '0;
            od_q  <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_DATA: lat_q <= wdata;
                REG_DIR:  dir_q <= wdata;
                REG_SEL:  sel_q <= wdata;
                REG_OD:   od_q  <= wdata;
            endcase
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_DATA: rdata = pad_sync;
            REG_DIR:  rdata = dir_q;
            REG_SEL:  rdata = sel_q;
            REG_OD:   rdata = od_q;
        endcase
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && $past(addr) == 2'd1) |-> (dir_q == $past(wdata))); // R2
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !($past(wr_en) && $past(addr) == 2'd2)) |-> $stable(sel_q)); // R2
endmodule

// File: rtl/pport_pin.sv
module pport_pin
    import pport_pkg::*;
#(
    parameter pin_kind_e KIND   = PIN_PLAIN,
    parameter bit        OD_CAP = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lat,
    input  logic dir,
    input  logic sel,
    input  logic od,
    input  logic pad_in,
    input  logic dev_out,
    input  logic brg_clk,
    input  logic alt_cts_in,
    output logic oe,
    output logic out,
    output logic dev_in
);
    logic ded_in;
    logic ded_out;
    logic drive_req;
    logic drive_val;
    logic od_on;
    logic fallback;

    assign ded_in    = sel & ~dir;
    assign ded_out   = sel & dir;
    assign drive_req = ded_out | (~sel & dir);
    assign od_on     = OD_CAP & od;

    generate
        if (KIND == PIN_CLK) begin : g_clk
            assign drive_val = ded_out ? brg_clk : lat;
            assign fallback  = brg_clk;
        end else if (KIND == PIN_CTS) begin : g_cts
            assign drive_val = ded_out ? dev_out : lat;
            assign fallback  = alt_cts_in;
        end else begin : g_plain
            assign drive_val = ded_out ? dev_out : lat;
            assign fallback  = 1'b0;
        end
    endgenerate

    assign oe  = drive_req & ~(od_on & drive_val);
    assign out = od_on ? 1'b0 : drive_val;
    assign dev_in = ded_in ? ((KIND == PIN_TXD0) ? 1'b0 : pad_in) : fallback;

    AST_DED_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel && !dir) |-> !oe); // R8
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (OD_CAP && od && oe) |-> !out); // R6
    AST_NONOD_PUSHPULL: assert property (@(posedge clk) disable iff (rst)
        (!OD_CAP && !sel && dir) |-> (oe && out == lat)); // R7
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
#(
    parameter int                 WIDTH    = 16,
    parameter int                 CLK_PIN  = 3,
    parameter int                 CTS_PIN  = 9,
    parameter int                 TXD0_PIN = 12,
    parameter logic [WIDTH-1:0]   OD_MASK  = 16'hF0F0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    input  logic [WIDTH-1:0] dev_out,
    output logic [WIDTH-1:0] dev_in,
    input  logic             brg_clk,
    input  logic             alt_cts_in
);
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] sel_q;
    logic [WIDTH-1:0] od_q;

    pport_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad      (pin_in),
        .pad_sync (pad_sync)
    );

    pport_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pad_sync (pad_sync),
        .rdata    (rdata),
        .lat_q    (lat_q),
        .dir_q    (dir_q),
        .sel_q    (sel_q),
        .od_q     (od_q)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            localparam pin_kind_e KIND =
                (i == CLK_PIN)  ? PIN_CLK  :
                (i == CTS_PIN)  ? PIN_CTS  :
                (i == TXD0_PIN) ? PIN_TXD0 : PIN_PLAIN;
            pport_pin #(.KIND(KIND), .OD_CAP(OD_MASK[i])) u_pin (
                .clk        (clk),
                .rst        (rst),
                .lat        (lat_q[i]),
                .dir        (dir_q[i]),
                .sel        (sel_q[i]),
                .od         (od_q[i]),
                .pad_in     (pin_in[i]),
                .dev_out    (dev_out[i]),
                .brg_clk    (brg_clk),
                .alt_cts_in (alt_cts_in),
                .oe         (pin_oe[i]),
                .out        (pin_out[i]),
                .dev_in     (dev_in[i])
            );
        end
    endgenerate

    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0)); // R1
    AST_TXD0_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (sel_q[TXD0_PIN] && !dir_q[TXD0_PIN]) |-> (!dev_in[TXD0_PIN] && !pin_oe[TXD0_PIN])); // R12
endmodule

// File: tb/sim_pport_ctrl.sv
module sim_pport_ctrl;
    localparam logic [15:0] ODM = 16'hF0F0;

    typedef struct {
        string       tag;
        logic [15:0] oe;
        logic [15:0] out;
        logic [15:0] dv;
        logic [15:0] rd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_oe;
    logic [15:0] pin_out;
    logic [15:0] dev_out = '0;
    logic [15:0] dev_in;
    logic        brg_clk = 1'b0;
    logic        alt_cts_in = 1'b0;

    logic [15:0] sh_lat = '0, sh_dir = '0, sh_sel = '0, sh_od = '0;
    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    pport_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .dev_out(dev_out), .dev_in(dev_in), .brg_clk(brg_clk), .alt_cts_in(alt_cts_in)
    );

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
        case (a)
            2'd0: sh_lat = d;
            2'd1: sh_dir = d;
            2'd2: sh_sel = d;
            default: sh_od = d;
        endcase
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [1:0] a);
        item_t it;
        it.tag = tag;
        for (int i = 0; i < 16; i++) begin
            logic din, dout, val, req, odo;
            din  = sh_sel[i] & ~sh_dir[i];
            dout = sh_sel[i] & sh_dir[i];
            val  = dout ? ((i == 3) ? brg_clk : dev_out[i]) : sh_lat[i];
            req  = dout | (~sh_sel[i] & sh_dir[i]);
            odo  = ODM[i] & sh_od[i];
            it.oe[i]  = req & ~(odo & val);
            it.out[i] = odo ? 1'b0 : val;
            if (din) it.dv[i] = (i == 12) ? 1'b0 : pin_in[i];
            else     it.dv[i] = (i == 3) ? brg_clk : (i == 9) ? alt_cts_in : 1'b0;
        end
        case (a)
            2'd0: it.rd = pin_in;
            2'd1: it.rd = sh_dir;
            2'd2: it.rd = sh_sel;
            default: it.rd = sh_od;
        endcase
        addr = a;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    always @(negedge clk) begin
        if (sbq.size() != 0) begin
            item_t it;
            it = sbq.pop_front();
            checks += 4;
            if (pin_oe !== it.oe) begin
                errors++; $display("FAIL %s pin_oe act=%h exp=%h", it.tag, pin_oe, it.oe);
            end
            if (pin_out !== it.out) begin
                errors++; $display("FAIL %s pin_out act=%h exp=%h", it.tag, pin_out, it.out);
            end
            if (dev_in !== it.dv) begin
                errors++; $display("FAIL %s dev_in act=%h exp=%h", it.tag, dev_in, it.dv);
            end
            if (rdata !== it.rd) begin
                errors++; $display("FAIL %s rdata act=%h exp=%h", it.tag, rdata, it.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        chk("R1 reset data", 2'd0);
        chk("R1 reset dir", 2'd1);
        chk("R1 reset sel", 2'd2);
        chk("R1 reset od", 2'd3);

        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'hA5A5);
        chk("R3 gpio out A5A5", 2'd1);
        wr(2'd0, 16'h5A5A);
        chk("R3 gpio out 5A5A", 2'd1);

        wr(2'd1, 16'h0000);
        pin_in = 16'h3C5A;
        settle();
        chk("R4 gpio in", 2'd1);
        chk("R5 sync read gpio", 2'd0);

        wr(2'd2, 16'hFFFF);
        pin_in = 16'hFFFF;
        settle();
        chk("R12 txd0 unused dedicated input", 2'd2);
        pin_in = 16'hC3A5;
        settle();
        chk("R5 sync read dedicated", 2'd0);
        chk("R8 dedicated input routing", 2'd2);

        wr(2'd1, 16'hFFFF);
        dev_out = 16'h1234;
        brg_clk = 1'b1;
        #1 chk("R9 dedicated output", 2'd1);
        brg_clk = 1'b0;
        #1 chk("R10 brg output low", 2'd1);
        wr(2'd3, 16'hFFFF);
        dev_out = 16'hFFFF;
        #1 chk("R9 dedicated out open-drain", 2'd3);

        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h00FF);
        chk("R6 od low-byte", 2'd3);
        chk("R7 od ignored low-byte", 2'd0);
        wr(2'd0, 16'hFF00);
        chk("R6 od high-byte", 2'd3);
        chk("R7 od ignored high-byte", 2'd2);

        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0000);
        brg_clk = 1'b1;
        #1 chk("R10 gpio fallback brg high", 2'd1);
        brg_clk = 1'b0;
        #1 chk("R10 gpio fallback brg low", 2'd1);

        alt_cts_in = 1'b1;
        #1 chk("R11 cts fallback high", 2'd2);
        wr(2'd2, 16'h0200);
        pin_in = 16'h0000;
        settle();
        chk("R11 cts from pad", 2'd2);
        alt_cts_in = 1'b0;

        wr(2'd1, 16'h6C39);
        wr(2'd2, 16'h9AC3);
        wr(2'd3, 16'h1E87);
        chk("R2 readback dir", 2'd1);
        chk("R2 readback sel", 2'd2);
        chk("R2 readback od", 2'd3);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule